// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block moves operand words between memory and a numeric coprocessor whenever the coprocessor asks for them. The asynchronous request input is first passed through a synchronizer. Each requested word is then carried by one indivisible pair of bus operations issued to a downstream bus sequencer. In the to-memory direction the pair reads the coprocessor data port (I/O address 00FA hex) and then writes the word to the memory operand. In the from-memory direction it reads the memory operand and then writes the word to the data port.

The acknowledge output is high for the whole of the first operation of every pair, so the coprocessor can withdraw its request in good time. Software or a control unit loads three values with a start pulse: the direction, the starting operand address and the number of words. The operand address steps by two after each word. The block raises a one-cycle done pulse when the count reaches zero.

A bus-hold request is honoured only between pairs. A pair is never split.

Top module: `cop_xfer_seq`

## Requirements
- R1: After reset, bus_req_o, cop_ack_o, done_o and hold_gnt_o are all 0.
- R2: A start with word count 0 issues no bus operation and raises done_o for exactly one cycle, in the cycle after the start cycle.
- R3: cop_req_i passes through SYNC_STAGES (default 2) flops. When it rises while the block is armed, the first operation's bus_req_o rises SYNC_STAGES+1 clock edges after cop_req_i is driven, and not earlier.
- R4: With dir_to_mem_i=1, each word is handled in two steps. First comes an I/O read (bus_io_o=1, bus_we_o=0) of address 0x00FA. Then comes a memory write (bus_io_o=0, bus_we_o=1) to the operand address, and bus_wdata_o carries the word returned by the read.
- R5: With dir_to_mem_i=0, each word is a memory read of the operand address followed by an I/O write to 0x00FA that carries the word read.
- R6: cop_ack_o is 1 during every cycle of the first operation of a pair and 0 during the second.
- R7: The operand address advances by 2 after each word. After the second operation of the last word completes, done_o is 1 for exactly one cycle and bus_req_o is 0.
- R8: The request is sampled only after the second operation of a pair completes. If it is inactive then, no further operation starts until it returns.
- R9: While bus_done_i is 0, an issued operation holds bus_req_o, bus_we_o, bus_io_o and bus_addr_o steady.
- R10: hold_gnt_o rises only when no pair is in progress: one cycle after the block is idle or armed with hold_req_i high. It falls one cycle after hold_req_i falls, and no operation is issued while it is high.
- R11: start_i has no effect while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches direction, address and count |
| dir_to_mem_i | input | 1 | 1: coprocessor to memory, 0: memory to coprocessor |
| base_addr_i | input | AW | First memory operand address |
| word_cnt_i | input | CW | Number of words to move |
| cop_req_i | input | 1 | Asynchronous operand request from the coprocessor |
| cop_ack_o | output | 1 | Acknowledge, high during first operation of a pair |
| hold_req_i | input | 1 | Bus hold request |
| hold_gnt_o | output | 1 | Bus hold granted |
| bus_req_o | output | 1 | Bus operation requested |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_io_o | output | 1 | 1 I/O space, 0 memory space |
| bus_addr_o | output | AW | Operation address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with bus_done_i |
| bus_done_i | input | 1 | Current operation completes this cycle |
| done_o | output | 1 | One-cycle pulse at end of sequence |

## Verification
The assertions take three things for granted. The bus sequencer raises bus_done_i only while an operation is requested. The coprocessor does not keep its request high after its last word. Hold requests arrive only from a master that waits for the grant.

The bench keeps within these limits. It drives bus_done_i only from the operation-serving task, after it has seen bus_req_o high. It withdraws cop_req_i in the first operation of the final pair, or when it wants a pause. It raises hold_req_i only inside a pair and keeps it up until it has seen the grant.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_OP1  = 2'd2,
    ST_OP2  = 2'd3
  } xfer_st_e;

  typedef struct packed {
    logic req;
    logic we;
    logic io;
  } bus_ctl_t;
endpackage

// File: rtl/cop_req_sync.sv
module cop_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cop_xfer_cnt.sv
module cop_xfer_cnt #(
  parameter int AW   = 24,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + STEP_V;
      cnt_q  <= cnt_q - ONE_V;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (cnt_q == ONE_V);
endmodule

// File: rtl/cop_xfer_fsm.sv
module cop_xfer_fsm
  import cop_xfer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     cnt_zero_i,
  input  logic     dir_i,
  input  logic     req_i,
  input  logic     hold_req_i,
  input  logic     bus_done_i,
  input  logic     last_i,
  output xfer_st_e state_o,
  output logic     dir_o,
  output logic     load_o,
  output logic     step_o,
  output logic     cap_o,
  output logic     done_o,
  output logic     hold_gnt_o
);
  xfer_st_e st_q, st_d;
  logic     dir_q, done_q, done_d, gnt_q, gnt_d;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    load_o = 1'b0;
    step_o = 1'b0;
    cap_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (cnt_zero_i) done_d = 1'b1;
        else begin
          load_o = 1'b1;
          st_d   = ST_ARM;
        end
      end
      // hold has priority over opening a new pair
      ST_ARM: if (req_i && !hold_req_i && !gnt_q) st_d = ST_OP1;
      ST_OP1: if (bus_done_i) begin
        cap_o = 1'b1;
        st_d  = ST_OP2;
      end
      ST_OP2: if (bus_done_i) begin
        step_o = 1'b1;
        if (last_i) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_ARM;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign gnt_d = hold_req_i && (st_q == ST_IDLE || st_q == ST_ARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      gnt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      gnt_q  <= gnt_d;
      if (load_o) dir_q <= dir_i;
    end
  end

  assign state_o    = st_q;
  assign dir_o      = dir_q;
  assign done_o     = done_q;
  assign hold_gnt_o = gnt_q;
endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
  import cop_xfer_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 16,
  parameter int          CW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_STEP   = 2,
  parameter logic [AW-1:0] PORT_ADDR = 24'h0000FA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_to_mem_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] word_cnt_i,
  input  logic          cop_req_i,
  output logic          cop_ack_o,
  input  logic          hold_req_i,
  output logic          hold_gnt_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_io_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_done_i,
  output logic          done_o
);
  xfer_st_e      st;
  logic          req_s, dir_q, load, step, cap, last;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] data_q;
  bus_ctl_t      ctl;

  cop_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cop_req_i),
    .q_o   (req_s)
  );

  cop_xfer_cnt #(.AW(AW), .CW(CW), .STEP(ADDR_STEP)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .base_i(base_addr_i),
    .cnt_i (word_cnt_i),
    .addr_o(op_addr),
    .last_o(last)
  );

  cop_xfer_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cnt_zero_i(word_cnt_i == '0),
    .dir_i     (dir_to_mem_i),
    .req_i     (req_s),
    .hold_req_i(hold_req_i),
    .bus_done_i(bus_done_i),
    .last_i    (last),
    .state_o   (st),
    .dir_o     (dir_q),
    .load_o    (load),
    .step_o    (step),
    .cap_o     (cap),
    .done_o    (done_o),
    .hold_gnt_o(hold_gnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  data_q <= '0;
    else if (cap) data_q <= bus_rdata_i;
  end

  // first op reads the source, second op writes the sink
  always_comb begin
    ctl        = '0;
    bus_addr_o = '0;
    unique case (st)
      ST_OP1: begin
        ctl.req    = 1'b1;
        ctl.io     = dir_q;
        bus_addr_o = dir_q ? PORT_ADDR : op_addr;
      end
      ST_OP2: begin
        ctl.req    = 1'b1;
        ctl.we     = 1'b1;
        ctl.io     = ~dir_q;
        bus_addr_o = dir_q ? op_addr : PORT_ADDR;
      end
      default: ;
    endcase
  end

  assign bus_req_o   = ctl.req;
  assign bus_we_o    = ctl.we;
  assign bus_io_o    = ctl.io;
  assign bus_wdata_o = (st == ST_OP2) ? data_q : '0;
  assign cop_ack_o   = (st == ST_OP1);
endmodule

// File: rtl/cop_xfer_seq_chk.sv
module cop_xfer_seq_chk #(
  parameter int            AW        = 24,
  parameter logic [AW-1:0] PORT_ADDR = 24'h0000FA
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cop_ack_o,
  input logic          hold_gnt_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_io_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_done_i,
  input logic          done_o
);
  AST_ACK_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_ack_o |-> (bus_req_o && !bus_we_o)); // R6

  AST_PORT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_io_o) |-> (bus_addr_o == PORT_ADDR)); // R4

  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && !$past(bus_req_o && bus_we_o))
      |-> $past(bus_req_o && !bus_we_o && bus_done_i)); // R5

  AST_OP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_we_o)
      && $stable(bus_io_o) && $stable(bus_addr_o))); // R9

  AST_NO_OP_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_gnt_o |-> !bus_req_o); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o); // R2
endmodule

bind cop_xfer_seq cop_xfer_seq_chk #(.AW(AW), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cop_ack_o (cop_ack_o),
  .hold_gnt_o(hold_gnt_o),
  .bus_req_o (bus_req_o),
  .bus_we_o  (bus_we_o),
  .bus_io_o  (bus_io_o),
  .bus_addr_o(bus_addr_o),
  .bus_done_i(bus_done_i),
  .done_o    (done_o)
);

// File: tb/sim_cop_xfer_seq.sv
module sim_cop_xfer_seq;
  localparam logic [23:0] PORT = 24'h0000FA;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, dir_to_mem_i = 1'b0;
  logic [23:0] base_addr_i = '0;
  logic [7:0]  word_cnt_i = '0;
  logic        cop_req_i = 1'b0, hold_req_i = 1'b0, bus_done_i = 1'b0;
  logic [15:0] bus_rdata_i = '0;
  logic        cop_ack_o, hold_gnt_o, bus_req_o, bus_we_o, bus_io_o, done_o;
  logic [23:0] bus_addr_o;
  logic [15:0] bus_wdata_o;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  cop_xfer_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dir_to_mem_i(dir_to_mem_i),
    .base_addr_i(base_addr_i), .word_cnt_i(word_cnt_i), .cop_req_i(cop_req_i),
    .cop_ack_o(cop_ack_o), .hold_req_i(hold_req_i), .hold_gnt_o(hold_gnt_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_io_o(bus_io_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_done_i(bus_done_i), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic start_seq(input logic dir, input logic [23:0] base, input logic [7:0] n);
    start_i = 1'b1; dir_to_mem_i = dir; base_addr_i = base; word_cnt_i = n;
    tick();
    start_i = 1'b0;
  endtask

  task automatic serve_op(input string rq, input logic we, input logic io,
                          input logic [23:0] addr, input logic [15:0] rdata,
                          input logic [15:0] wdata, input int waits,
                          input bit ack, input bit drop_req);
    int n = 0;
    while (!bus_req_o && n < 50) begin tick(); n++; end
    chk(bus_req_o, rq, "bus_req", 32'(bus_req_o), 1);
    if (drop_req) cop_req_i = 1'b0;
    chk(bus_we_o == we, rq, "we", 32'(bus_we_o), 32'(we));
    chk(bus_io_o == io, rq, "io", 32'(bus_io_o), 32'(io));
    chk(bus_addr_o == addr, rq, "addr", 32'(bus_addr_o), 32'(addr));
    chk(cop_ack_o == ack, "R6", "ack", 32'(cop_ack_o), 32'(ack));
    chk(!hold_gnt_o, "R10", "gnt in pair", 32'(hold_gnt_o), 0);
    if (we) chk(bus_wdata_o == wdata, rq, "wdata", 32'(bus_wdata_o), 32'(wdata));
    for (int i = 0; i < waits; i++) begin
      bus_done_i = 1'b0;
      tick();
      chk(bus_req_o && bus_addr_o == addr && bus_we_o == we, "R9", "held op",
          32'(bus_addr_o), 32'(addr));
    end
    bus_rdata_i = rdata; bus_done_i = 1'b1;
    tick();
    bus_done_i = 1'b0; bus_rdata_i = '0;
  endtask

  task automatic chk_done();
    chk(done_o && !bus_req_o, "R7", "done after last", 32'(done_o), 1);
    tick();
    chk(!done_o, "R7", "done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_reset();
    chk(!bus_req_o && !cop_ack_o && !done_o && !hold_gnt_o, "R1", "reset outs",
        {28'd0, bus_req_o, cop_ack_o, done_o, hold_gnt_o}, 0);
  endtask

  task automatic t_zero_count();
    start_seq(1'b1, 24'h000400, 8'd0);
    chk(done_o && !bus_req_o, "R2", "zero count done", 32'(done_o), 1);
    tick();
    chk(!done_o && !bus_req_o, "R2", "zero count pulse", 32'(done_o), 0);
  endtask

  task automatic t_sync_latency();
    start_seq(1'b1, 24'h000100, 8'd1);
    cop_req_i = 1'b1;
    tick(); chk(!bus_req_o, "R3", "edge1", 32'(bus_req_o), 0);
    tick(); chk(!bus_req_o, "R3", "edge2", 32'(bus_req_o), 0);
    tick(); chk(bus_req_o, "R3", "edge3", 32'(bus_req_o), 1);
    serve_op("R4", 1'b0, 1'b1, PORT, 16'h1234, 16'h0, 0, 1'b1, 1'b1);
    serve_op("R4", 1'b1, 1'b0, 24'h000100, 16'h0, 16'h1234, 0, 1'b0, 1'b0);
    chk_done();
  endtask

  task automatic t_to_mem_multi();
    start_seq(1'b1, 24'h002000, 8'd3);
    cop_req_i = 1'b1;
    for (int w = 0; w < 3; w++) begin
      serve_op("R4", 1'b0, 1'b1, PORT, 16'hA000 + 16'(w), 16'h0, 2, 1'b1, w == 2);
      serve_op("R7", 1'b1, 1'b0, 24'h002000 + 24'(2*w), 16'h0, 16'hA000 + 16'(w),
               1, 1'b0, 1'b0);
    end
    chk_done();
  endtask

  task automatic t_from_mem();
    start_seq(1'b0, 24'h03FFFE, 8'd2);
    cop_req_i = 1'b1;
    for (int w = 0; w < 2; w++) begin
      serve_op("R5", 1'b0, 1'b0, 24'h03FFFE + 24'(2*w), 16'h5A50 + 16'(w), 16'h0,
               w, 1'b1, w == 1);
      serve_op("R5", 1'b1, 1'b1, PORT, 16'h0, 16'h5A50 + 16'(w), 0, 1'b0, 1'b0);
    end
    chk_done();
  endtask

  task automatic t_pause();
    bit quiet = 1'b1;
    start_seq(1'b1, 24'h000800, 8'd2);
    cop_req_i = 1'b1;
    serve_op("R8", 1'b0, 1'b1, PORT, 16'h0101, 16'h0, 0, 1'b1, 1'b1);
    serve_op("R8", 1'b1, 1'b0, 24'h000800, 16'h0, 16'h0101, 0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      if (bus_req_o) quiet = 1'b0;
      tick();
    end
    chk(quiet, "R8", "no op without request", 32'(quiet), 1);
    chk(!done_o, "R8", "not done while paused", 32'(done_o), 0);
    cop_req_i = 1'b1;
    serve_op("R8", 1'b0, 1'b1, PORT, 16'h0202, 16'h0, 0, 1'b1, 1'b1);
    serve_op("R8", 1'b1, 1'b0, 24'h000802, 16'h0, 16'h0202, 0, 1'b0, 1'b0);
    chk_done();
  endtask

  task automatic t_hold();
    bit quiet = 1'b1;
    start_seq(1'b0, 24'h001000, 8'd2);
    cop_req_i = 1'b1;
    // raise hold inside the pair, before the first op completes
    while (!bus_req_o) tick();
    hold_req_i = 1'b1;
    serve_op("R10", 1'b0, 1'b0, 24'h001000, 16'h7777, 16'h0, 1, 1'b1, 1'b0);
    serve_op("R10", 1'b1, 1'b1, PORT, 16'h0, 16'h7777, 1, 1'b0, 1'b0);
    chk(!hold_gnt_o && !bus_req_o, "R10", "gnt not yet", 32'(hold_gnt_o), 0);
    tick();
    chk(hold_gnt_o, "R10", "gnt after pair", 32'(hold_gnt_o), 1);
    for (int i = 0; i < 4; i++) begin
      if (bus_req_o) quiet = 1'b0;
      tick();
    end
    chk(quiet && hold_gnt_o, "R10", "no op while held", 32'(quiet), 1);
    hold_req_i = 1'b0;
    tick();
    chk(!hold_gnt_o && !bus_req_o, "R10", "gnt released", 32'(hold_gnt_o), 0);
    serve_op("R10", 1'b0, 1'b0, 24'h001002, 16'h8888, 16'h0, 0, 1'b1, 1'b1);
    serve_op("R10", 1'b1, 1'b1, PORT, 16'h0, 16'h8888, 0, 1'b0, 1'b0);
    chk_done();
  endtask

  task automatic t_start_ignored();
    start_seq(1'b1, 24'h000500, 8'd2);
    start_i = 1'b1; dir_to_mem_i = 1'b0; base_addr_i = 24'h000900; word_cnt_i = 8'd0;
    tick();
    start_i = 1'b0;
    chk(!done_o, "R11", "restart ignored", 32'(done_o), 0);
    cop_req_i = 1'b1;
    for (int w = 0; w < 2; w++) begin
      serve_op("R11", 1'b0, 1'b1, PORT, 16'hC0DE + 16'(w), 16'h0, 0, 1'b1, w == 1);
      serve_op("R11", 1'b1, 1'b0, 24'h000500 + 24'(2*w), 16'h0, 16'hC0DE + 16'(w),
               0, 1'b0, 1'b0);
    end
    chk_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_zero_count();
    t_sync_latency();
    t_to_mem_multi();
    t_from_mem();
    t_pause();
    t_hold();
    t_start_ignored();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule